// File: doc/BRIEF.md
# Machine-Mode Trap Controller

This block is the trap unit of a 32-bit hart that runs only at the highest privilege level. It keeps the status, interrupt-enable, interrupt-pending, cause, exception-PC, trap-value, trap-vector and vector-table-base registers behind a plain register read/write port. The pipeline offers it synchronous exceptions, each with a cause code, the address of the faulting instruction and an extra word (faulting address or instruction bits). It also gives it three interrupt lines and a trap-return strobe. The block picks the event to act on, updates its registers and emits a one-cycle redirect to the next PC.

Exceptions win over a return and over interrupts presented in the same cycle. Interrupts need the global enable bit and a matching enable bit. They are served lowest bit first. The vector register selects direct, per-cause-offset or table-fetch dispatch for interrupts. In table mode a one-word read goes out at the table base. Registers change only when a good response comes back. A response that signals an error abandons the trap. Interrupt eligibility is evaluated every cycle, so it takes effect at once after a status or enable write and after a return.

Top module: `mtrap_ctrl`

## Requirements
- R1: Registers sit at 12-bit addresses: status 0x300, enable 0x304, vector 0x305, table base 0x307, exception-PC 0x341, cause 0x342, trap value 0x343, pending 0x344. The vector and table-base registers take every written bit. Any other address reads 0 and ignores writes.
- R2: Status shows only the global enable (bit 3), the saved enable (bit 7) and the previous-mode field (bits 12:11). The field always reads 2'b11. Bits 3 and 7 are the only writable bits. After reset status reads 0x00001800.
- R3: The enable register keeps only bits 3, 7 and 11 (software, timer, external). The pending register reads the three interrupt lines at those bits and ignores writes.
- R4: The cause register keeps bit 31 plus the low log2(NUM_IRQ) code bits (4 by default). Both register writes and trap entry are masked this way, and every other bit reads 0.
- R5: An accepted exception is taken whatever the global enable. It writes the instruction address to the exception-PC and {0, code} to the cause. It redirects to the vector base with bits 1:0 cleared, in every vector mode. An environment call is reported with its code 11 unchanged.
- R6: On an exception the trap value gets the extra word for codes 0, 4 and 6, and the instruction address for code 3. For code 2 it gets the extra word, with only the low 16 bits kept when bits 1:0 are not 2'b11. Every other code writes 0. Interrupts leave the trap value unchanged.
- R7: Trap entry copies the global enable into the saved enable and clears the global enable. trap_taken pulses for one cycle, together with redirect_valid, in the cycle after acceptance.
- R8: An interrupt is taken only when the global enable is set and some line is pending with its enable bit set. The lowest such bit gives the cause code. The cause gets bit 31 set, and the exception-PC gets next_pc.
- R9: For interrupts, vector mode 0 or 2 redirects to the base, and mode 1 redirects to base + 4 * code.
- R10: In vector mode 3 an interrupt raises tbl_req with tbl_addr equal to the table base until tbl_rvalid. No register changes before then. A good response commits the trap and redirects to tbl_rdata.
- R11: A table response with tbl_err set changes no register and gives no trap_taken and no redirect.
- R12: An exception presented together with an interrupt or a return is the only event acted on.
- R13: A return (not beaten by an exception) copies the saved enable into the global enable, sets the saved enable, and redirects to the exception-PC without trap_taken.
- R14: The exception-PC is stored under an alignment mask, on writes and on trap entry: bit 0 is cleared with compressed support (default), bits 1:0 without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register address for read and write |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| irq_sw | input | 1 | Software interrupt line |
| irq_timer | input | 1 | Timer interrupt line |
| irq_ext | input | 1 | External interrupt line |
| exc_valid | input | 1 | Synchronous exception request |
| exc_cause | input | 5 | Exception code |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_info | input | 32 | Faulting address or instruction bits |
| next_pc | input | 32 | Address of the next instruction, saved on interrupts |
| mret_valid | input | 1 | Trap-return strobe |
| trap_taken | output | 1 | One-cycle pulse for every trap entered |
| redirect_valid | output | 1 | Next PC is valid |
| redirect_pc | output | 32 | Next PC |
| tbl_req | output | 1 | Table word read request, held until answered |
| tbl_addr | output | 32 | Table word address |
| tbl_rvalid | input | 1 | Table read response |
| tbl_rdata | input | 32 | Table word |
| tbl_err | input | 1 | Table read failed |

## Verification
The properties assume the pipeline offers a new exception or return only when no table read is outstanding. They also assume tbl_rvalid comes only while tbl_req is high. The bench keeps to this: it answers each table request once, on the cycle after it sees the request, and presents no other event until then. Register writes never share a cycle with a trap or a return in the stimulus. Interrupt lines are raised only in the scenarios that expect them and are dropped as soon as the trap is seen, so no trap is taken that a scenario does not expect.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    localparam int XLEN    = 32;
    localparam int CODE_W  = 5;
    localparam int NUM_SRC = 3;
    localparam int PEND_W  = 12;

    typedef logic [XLEN-1:0] word_t;

    // register addresses
    localparam logic [11:0] A_STATUS = 12'h300;
    localparam logic [11:0] A_IE     = 12'h304;
    localparam logic [11:0] A_TVEC   = 12'h305;
    localparam logic [11:0] A_VTBASE = 12'h307;
    localparam logic [11:0] A_EPC    = 12'h341;
    localparam logic [11:0] A_CAUSE  = 12'h342;
    localparam logic [11:0] A_TVAL   = 12'h343;
    localparam logic [11:0] A_IP     = 12'h344;

    // status bit positions
    localparam int ST_GIE  = 3;
    localparam int ST_SGIE = 7;

    // interrupt source bit positions: software, timer, external
    localparam int SRC_POS [NUM_SRC] = '{3, 7, 11};

    // exception codes with a dedicated trap value
    localparam logic [CODE_W-1:0] C_FETCH_ALIGN = 5'd0;
    localparam logic [CODE_W-1:0] C_ILLEGAL     = 5'd2;
    localparam logic [CODE_W-1:0] C_BREAK       = 5'd3;
    localparam logic [CODE_W-1:0] C_LOAD_ALIGN  = 5'd4;
    localparam logic [CODE_W-1:0] C_STORE_ALIGN = 5'd6;

    typedef enum logic [1:0] {
        VM_DIRECT = 2'd0,
        VM_OFFSET = 2'd1,
        VM_RSVD   = 2'd2,
        VM_TABLE  = 2'd3
    } vec_mode_e;

    typedef enum logic {
        PH_IDLE,
        PH_FETCH
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic                gie;
        logic                sgie;
        logic [NUM_SRC-1:0]  ien;
        logic                cause_irq;
        logic [CODE_W-1:0]   cause_code;
        word_t               epc;
        word_t               tval;
        word_t               tvec;
        word_t               vtbase;
        logic [CODE_W-1:0]   hold_code;
        word_t               hold_epc;
        logic                redir_v;
        word_t               redir_pc;
        logic                taken;
    } regs_t;

endpackage

// File: rtl/mtrap_irq_pick.sv
module mtrap_irq_pick #(
    parameter int W = 12
) (
    input  logic [W-1:0]         req_i,
    output logic                 any_o,
    output logic [$clog2(W)-1:0] idx_o
);
    localparam int IW = $clog2(W);

    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/mtrap_tval.sv
module mtrap_tval
    import mtrap_pkg::*;
#(
    parameter bit RVC = 1'b1
) (
    input  logic [CODE_W-1:0] code_i,
    input  word_t             pc_i,
    input  word_t             info_i,
    output word_t             tval_o
);
    always_comb begin
        case (code_i)
            C_FETCH_ALIGN,
            C_LOAD_ALIGN,
            C_STORE_ALIGN: tval_o = info_i;
            C_ILLEGAL: begin
                if (RVC && (info_i[1:0] != 2'b11)) begin
                    tval_o = {16'h0000, info_i[15:0]};
                end else begin
                    tval_o = info_i;
                end
            end
            C_BREAK:       tval_o = pc_i;
            default:       tval_o = '0;
        endcase
    end

endmodule

// File: rtl/mtrap_vector.sv
module mtrap_vector
    import mtrap_pkg::*;
(
    input  word_t             tvec_i,
    input  logic [CODE_W-1:0] code_i,
    output word_t             base_o,
    output word_t             irq_target_o,
    output logic              irq_table_o
);
    vec_mode_e mode;

    always_comb begin
        mode   = vec_mode_e'(tvec_i[1:0]);
        base_o = {tvec_i[XLEN-1:2], 2'b00};
        if (mode == VM_OFFSET) begin
            irq_target_o = base_o + (word_t'(code_i) << 2);
        end else begin
            irq_target_o = base_o;
        end
        irq_table_o = (mode == VM_TABLE);
    end

endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter bit RVC     = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        irq_sw,
    input  logic        irq_timer,
    input  logic        irq_ext,
    input  logic        exc_valid,
    input  logic [4:0]  exc_cause,
    input  logic [31:0] exc_pc,
    input  logic [31:0] exc_info,
    input  logic [31:0] next_pc,
    input  logic        mret_valid,
    output logic        trap_taken,
    output logic        redirect_valid,
    output logic [31:0] redirect_pc,
    output logic        tbl_req,
    output logic [31:0] tbl_addr,
    input  logic        tbl_rvalid,
    input  logic [31:0] tbl_rdata,
    input  logic        tbl_err
);
    localparam int KEEP_W = $clog2(NUM_IRQ + 1) - 1;
    localparam logic [CODE_W-1:0] CODE_KEEP = CODE_W'((1 << KEEP_W) - 1);
    localparam word_t PC_MASK = RVC ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;
    localparam int IW = $clog2(PEND_W);

    regs_t r_d, r_q;

    logic [NUM_SRC-1:0] lines;
    logic [PEND_W-1:0]  line_vec;
    logic [PEND_W-1:0]  ready_vec;
    logic               irq_any;
    logic [IW-1:0]      irq_idx;
    logic [CODE_W-1:0]  irq_code;
    word_t              exc_tval;
    word_t              vec_base;
    word_t              irq_target;
    logic               irq_table;

    assign lines = {irq_ext, irq_timer, irq_sw};

    always_comb begin
        line_vec  = '0;
        ready_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            line_vec[SRC_POS[i]]  = lines[i];
            ready_vec[SRC_POS[i]] = lines[i] & r_q.ien[i];
        end
    end

    mtrap_irq_pick #(.W(PEND_W)) i_pick (
        .req_i (ready_vec),
        .any_o (irq_any),
        .idx_o (irq_idx)
    );

    assign irq_code = CODE_W'(irq_idx);

    mtrap_tval #(.RVC(RVC)) i_tval (
        .code_i (exc_cause),
        .pc_i   (exc_pc),
        .info_i (exc_info),
        .tval_o (exc_tval)
    );

    mtrap_vector i_vec (
        .tvec_i       (r_q.tvec),
        .code_i       (irq_code),
        .base_o       (vec_base),
        .irq_target_o (irq_target),
        .irq_table_o  (irq_table)
    );

    // next-state computation
    always_comb begin
        logic              enter;
        logic              ent_irq;
        logic [CODE_W-1:0] ent_code;
        word_t             ent_epc;
        word_t             ent_pc;

        r_d         = r_q;
        r_d.redir_v = 1'b0;
        r_d.taken   = 1'b0;
        enter       = 1'b0;
        ent_irq     = 1'b0;
        ent_code    = '0;
        ent_epc     = '0;
        ent_pc      = '0;

        if (csr_we) begin
            case (csr_addr)
                A_STATUS: begin
                    r_d.gie  = csr_wdata[ST_GIE];
                    r_d.sgie = csr_wdata[ST_SGIE];
                end
                A_IE: begin
                    for (int i = 0; i < NUM_SRC; i++) begin
                        r_d.ien[i] = csr_wdata[SRC_POS[i]];
                    end
                end
                A_TVEC:   r_d.tvec   = csr_wdata;
                A_VTBASE: r_d.vtbase = csr_wdata;
                A_EPC:    r_d.epc    = csr_wdata & PC_MASK;
                A_CAUSE: begin
                    r_d.cause_irq  = csr_wdata[XLEN-1];
                    r_d.cause_code = csr_wdata[CODE_W-1:0] & CODE_KEEP;
                end
                A_TVAL:   r_d.tval   = csr_wdata;
                default: ;
            endcase
        end

        if (r_q.phase == PH_IDLE) begin
            if (exc_valid) begin
                enter    = 1'b1;
                ent_irq  = 1'b0;
                ent_code = exc_cause;
                ent_epc  = exc_pc;
                ent_pc   = vec_base;
                r_d.tval = exc_tval;
            end else if (mret_valid) begin
                r_d.gie      = r_q.sgie;
                r_d.sgie     = 1'b1;
                r_d.redir_v  = 1'b1;
                r_d.redir_pc = r_q.epc;
            end else if (r_q.gie && irq_any) begin
                if (irq_table) begin
                    r_d.phase     = PH_FETCH;
                    r_d.hold_code = irq_code;
                    r_d.hold_epc  = next_pc;
                end else begin
                    enter    = 1'b1;
                    ent_irq  = 1'b1;
                    ent_code = irq_code;
                    ent_epc  = next_pc;
                    ent_pc   = irq_target;
                end
            end
        end else if (tbl_rvalid) begin
            r_d.phase = PH_IDLE;
            if (!tbl_err) begin
                enter    = 1'b1;
                ent_irq  = 1'b1;
                ent_code = r_q.hold_code;
                ent_epc  = r_q.hold_epc;
                ent_pc   = tbl_rdata;
            end
        end

        if (enter) begin
            r_d.cause_irq  = ent_irq;
            r_d.cause_code = ent_code & CODE_KEEP;
            r_d.epc        = ent_epc & PC_MASK;
            r_d.sgie       = r_q.gie;
            r_d.gie        = 1'b0;
            r_d.redir_v    = 1'b1;
            r_d.redir_pc   = ent_pc;
            r_d.taken      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // register read port
    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            A_STATUS: begin
                csr_rdata[12:11]   = 2'b11;
                csr_rdata[ST_GIE]  = r_q.gie;
                csr_rdata[ST_SGIE] = r_q.sgie;
            end
            A_IE: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    csr_rdata[SRC_POS[i]] = r_q.ien[i];
                end
            end
            A_IP:     csr_rdata = word_t'(line_vec);
            A_TVEC:   csr_rdata = r_q.tvec;
            A_VTBASE: csr_rdata = r_q.vtbase;
            A_EPC:    csr_rdata = r_q.epc;
            A_CAUSE:  csr_rdata = {r_q.cause_irq, {(XLEN-1-CODE_W){1'b0}}, r_q.cause_code};
            A_TVAL:   csr_rdata = r_q.tval;
            default:  csr_rdata = '0;
        endcase
    end

    assign trap_taken     = r_q.taken;
    assign redirect_valid = r_q.redir_v;
    assign redirect_pc    = r_q.redir_pc;
    assign tbl_req        = (r_q.phase == PH_FETCH);
    assign tbl_addr       = r_q.vtbase;

endmodule

// File: rtl/mtrap_ctrl_chk.sv
module mtrap_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exc_valid,
    input logic        mret_valid,
    input logic        tbl_req,
    input logic        tbl_rvalid,
    input logic        tbl_err,
    input logic [31:0] tbl_rdata,
    input logic        trap_taken,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc,
    input logic        gie,
    input logic        sgie,
    input logic        cause_irq
);

    // R7
    entry_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (!gie && redirect_valid));

    // R10
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && !tbl_rvalid) |=> tbl_req);

    // R10
    table_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && tbl_rvalid && !tbl_err) |=>
            (trap_taken && redirect_pc == $past(tbl_rdata) && cause_irq));

    // R11
    table_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && tbl_rvalid && tbl_err) |=> (!trap_taken && !redirect_valid && !tbl_req));

    // R12
    exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !tbl_req) |=> (trap_taken && !cause_irq));

    // R13
    return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_valid && !exc_valid && !tbl_req) |=>
            (redirect_valid && !trap_taken && sgie && gie == $past(sgie)));

endmodule

bind mtrap_ctrl mtrap_ctrl_chk i_mtrap_ctrl_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .exc_valid      (exc_valid),
    .mret_valid     (mret_valid),
    .tbl_req        (tbl_req),
    .tbl_rvalid     (tbl_rvalid),
    .tbl_err        (tbl_err),
    .tbl_rdata      (tbl_rdata),
    .trap_taken     (trap_taken),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .gie            (r_q.gie),
    .sgie           (r_q.sgie),
    .cause_irq      (r_q.cause_irq)
);

// File: tb/test_mtrap_ctrl.sv
module test_mtrap_ctrl;

    localparam int CLK_PERIOD = 10;

    localparam logic [11:0] A_STATUS = 12'h300;
    localparam logic [11:0] A_IE     = 12'h304;
    localparam logic [11:0] A_TVEC   = 12'h305;
    localparam logic [11:0] A_VTBASE = 12'h307;
    localparam logic [11:0] A_EPC    = 12'h341;
    localparam logic [11:0] A_CAUSE  = 12'h342;
    localparam logic [11:0] A_TVAL   = 12'h343;
    localparam logic [11:0] A_IP     = 12'h344;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_we;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        irq_sw, irq_timer, irq_ext;
    logic        exc_valid;
    logic [4:0]  exc_cause;
    logic [31:0] exc_pc, exc_info, next_pc;
    logic        mret_valid;
    logic        trap_taken, redirect_valid;
    logic [31:0] redirect_pc;
    logic        tbl_req;
    logic [31:0] tbl_addr;
    logic        tbl_rvalid;
    logic [31:0] tbl_rdata;
    logic        tbl_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtrap_ctrl i_mtrap_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .csr_we         (csr_we),
        .csr_addr       (csr_addr),
        .csr_wdata      (csr_wdata),
        .csr_rdata      (csr_rdata),
        .irq_sw         (irq_sw),
        .irq_timer      (irq_timer),
        .irq_ext        (irq_ext),
        .exc_valid      (exc_valid),
        .exc_cause      (exc_cause),
        .exc_pc         (exc_pc),
        .exc_info       (exc_info),
        .next_pc        (next_pc),
        .mret_valid     (mret_valid),
        .trap_taken     (trap_taken),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .tbl_req        (tbl_req),
        .tbl_addr       (tbl_addr),
        .tbl_rvalid     (tbl_rvalid),
        .tbl_rdata      (tbl_rdata),
        .tbl_err        (tbl_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        csr_addr = a;
        #1;
        v = csr_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        csr_we    = 1'b1;
        csr_addr  = a;
        csr_wdata = v;
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // present one exception; returns at the negedge where outputs are valid
    task automatic raise_exc(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] info);
        @(negedge clk);
        exc_valid = 1'b1;
        exc_cause = c;
        exc_pc    = pc;
        exc_info  = info;
        @(negedge clk);
        exc_valid = 1'b0;
    endtask

    task automatic tval_case(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] info,
                             input logic [31:0] exp_tval);
        raise_exc(c, pc, info);
        chk("R6 trap_taken", {31'd0, trap_taken}, 32'd1);
        rd_chk("R6 tval", A_TVAL, exp_tval);
        rd_chk("R5 cause", A_CAUSE, {27'd0, c});
    endtask

    task automatic t_reset();
        rd_chk("R2 status reset", A_STATUS, 32'h0000_1800);
        rd_chk("R3 ie reset", A_IE, 32'h0);
        rd_chk("R4 cause reset", A_CAUSE, 32'h0);
        chk("R7 no trap at reset", {31'd0, trap_taken}, 32'd0);
        chk("R7 no redirect at reset", {31'd0, redirect_valid}, 32'd0);
        chk("R10 no request at reset", {31'd0, tbl_req}, 32'd0);
    endtask

    task automatic t_csr_masks();
        wr(A_STATUS, 32'hFFFF_FFFF);
        rd_chk("R2 status all ones", A_STATUS, 32'h0000_1888);
        wr(A_STATUS, 32'h0);
        rd_chk("R2 status cleared", A_STATUS, 32'h0000_1800);
        wr(A_IE, 32'hFFFF_FFFF);
        rd_chk("R3 ie mask", A_IE, 32'h0000_0888);
        wr(A_IE, 32'h0);
        wr(A_IP, 32'hFFFF_FFFF);
        rd_chk("R3 ip write ignored", A_IP, 32'h0);
        irq_timer = 1'b1;
        rd_chk("R3 ip shows timer line", A_IP, 32'h0000_0080);
        irq_timer = 1'b0;
        wr(A_CAUSE, 32'hFFFF_FFFF);
        rd_chk("R4 cause mask", A_CAUSE, 32'h8000_000F);
        wr(A_EPC, 32'h0000_1233);
        rd_chk("R14 epc write mask", A_EPC, 32'h0000_1232);
        wr(12'h340, 32'hDEAD_BEEF);
        rd_chk("R1 unmapped reads zero", 12'h340, 32'h0);
        wr(A_VTBASE, 32'h1234_5677);
        rd_chk("R1 table base full width", A_VTBASE, 32'h1234_5677);
    endtask

    task automatic t_exceptions();
        wr(A_TVEC, 32'h0000_0201);
        wr(A_STATUS, 32'h0000_0008);
        raise_exc(5'd2, 32'h0000_0400, 32'hABCD_1234);
        chk("R5 trap_taken", {31'd0, trap_taken}, 32'd1);
        chk("R5 redirect_valid", {31'd0, redirect_valid}, 32'd1);
        chk("R5 base redirect in offset mode", redirect_pc, 32'h0000_0200);
        rd_chk("R5 epc", A_EPC, 32'h0000_0400);
        rd_chk("R5 cause", A_CAUSE, 32'h0000_0002);
        rd_chk("R6 illegal compressed tval", A_TVAL, 32'h0000_1234);
        rd_chk("R7 status after entry", A_STATUS, 32'h0000_1880);
        @(negedge clk);
        chk("R7 pulse one cycle", {31'd0, trap_taken}, 32'd0);
        // exception taken with global enable clear
        tval_case(5'd2,  32'h0000_0500, 32'hABCD_1237, 32'hABCD_1237);
        rd_chk("R7 saved enable copied from cleared", A_STATUS, 32'h0000_1800);
        tval_case(5'd3,  32'h0000_0600, 32'h1111_1111, 32'h0000_0600);
        tval_case(5'd4,  32'h0000_0604, 32'h0000_2002, 32'h0000_2002);
        tval_case(5'd6,  32'h0000_0608, 32'h0000_3001, 32'h0000_3001);
        tval_case(5'd0,  32'h0000_060C, 32'h0000_0701, 32'h0000_0701);
        tval_case(5'd5,  32'h0000_0610, 32'h5555_5555, 32'h0);
        tval_case(5'd11, 32'h0000_0615, 32'h7777_7777, 32'h0);
        rd_chk("R14 epc entry mask", A_EPC, 32'h0000_0614);
        rd_chk("R5 ecall code kept", A_CAUSE, 32'h0000_000B);
    endtask

    task automatic t_return();
        wr(A_STATUS, 32'h0000_0080);
        @(negedge clk);
        mret_valid = 1'b1;
        @(negedge clk);
        mret_valid = 1'b0;
        chk("R13 redirect_valid", {31'd0, redirect_valid}, 32'd1);
        chk("R13 redirect to epc", redirect_pc, 32'h0000_0614);
        chk("R13 no trap_taken", {31'd0, trap_taken}, 32'd0);
        rd_chk("R13 status after return", A_STATUS, 32'h0000_1888);
        wr(A_STATUS, 32'h0);
    endtask

    task automatic t_interrupts();
        wr(A_TVEC, 32'h0000_0301);
        wr(A_IE, 32'h0000_0888);
        next_pc   = 32'h0000_1006;
        irq_timer = 1'b1;
        irq_ext   = 1'b1;
        // global enable clear: nothing happens
        repeat (3) begin
            @(negedge clk);
            chk("R8 no trap while disabled", {31'd0, redirect_valid}, 32'd0);
        end
        wr(A_STATUS, 32'h0000_0008);
        @(negedge clk);
        irq_timer = 1'b0;
        irq_ext   = 1'b0;
        chk("R8 interrupt taken", {31'd0, trap_taken}, 32'd1);
        chk("R9 offset redirect", redirect_pc, 32'h0000_031C);
        rd_chk("R8 lowest cause wins", A_CAUSE, 32'h8000_0007);
        rd_chk("R8 epc is next pc", A_EPC, 32'h0000_1006);
        rd_chk("R7 status after irq", A_STATUS, 32'h0000_1880);

        // enable bit missing, then re-evaluated on enable write
        wr(A_TVEC, 32'h0000_0300);
        wr(A_IE, 32'h0000_0880);
        irq_sw  = 1'b1;
        next_pc = 32'h0000_2000;
        wr(A_STATUS, 32'h0000_0008);
        @(negedge clk);
        chk("R8 masked source ignored", {31'd0, redirect_valid}, 32'd0);
        wr(A_IE, 32'h0000_0888);
        @(negedge clk);
        irq_sw = 1'b0;
        chk("R8 taken after enable write", {31'd0, trap_taken}, 32'd1);
        chk("R9 direct redirect", redirect_pc, 32'h0000_0300);
        rd_chk("R8 software cause", A_CAUSE, 32'h8000_0003);
    endtask

    task automatic t_table();
        logic [31:0] cause_before, epc_before;
        wr(A_TVEC, 32'h0000_0303);
        wr(A_VTBASE, 32'h0000_8000);
        wr(A_IE, 32'h0000_0888);
        rd(A_CAUSE, cause_before);
        next_pc = 32'h0000_3004;
        irq_ext = 1'b1;
        wr(A_STATUS, 32'h0000_0008);
        @(negedge clk);
        chk("R10 request raised", {31'd0, tbl_req}, 32'd1);
        chk("R10 request address", tbl_addr, 32'h0000_8000);
        chk("R10 no trap before data", {31'd0, trap_taken}, 32'd0);
        rd_chk("R10 cause unchanged while waiting", A_CAUSE, cause_before);
        tbl_rvalid = 1'b1;
        tbl_rdata  = 32'h0000_4444;
        @(negedge clk);
        tbl_rvalid = 1'b0;
        irq_ext    = 1'b0;
        chk("R10 trap_taken on data", {31'd0, trap_taken}, 32'd1);
        chk("R10 redirect to table word", redirect_pc, 32'h0000_4444);
        chk("R10 request dropped", {31'd0, tbl_req}, 32'd0);
        rd_chk("R10 cause external", A_CAUSE, 32'h8000_000B);
        rd_chk("R10 epc", A_EPC, 32'h0000_3004);

        // failing table read
        rd(A_CAUSE, cause_before);
        rd(A_EPC, epc_before);
        next_pc = 32'h0000_5008;
        irq_sw  = 1'b1;
        wr(A_STATUS, 32'h0000_0008);
        @(negedge clk);
        chk("R11 request raised", {31'd0, tbl_req}, 32'd1);
        tbl_rvalid = 1'b1;
        tbl_err    = 1'b1;
        tbl_rdata  = 32'h0000_9999;
        @(negedge clk);
        tbl_rvalid = 1'b0;
        tbl_err    = 1'b0;
        irq_sw     = 1'b0;
        chk("R11 no trap_taken", {31'd0, trap_taken}, 32'd0);
        chk("R11 no redirect", {31'd0, redirect_valid}, 32'd0);
        rd_chk("R11 cause unchanged", A_CAUSE, cause_before);
        rd_chk("R11 epc unchanged", A_EPC, epc_before);
        rd_chk("R11 status unchanged", A_STATUS, 32'h0000_1808);
        wr(A_STATUS, 32'h0);

        // exceptions ignore table mode
        raise_exc(5'd2, 32'h0000_0700, 32'h0000_0013);
        chk("R5 exception uses base in table mode", redirect_pc, 32'h0000_0300);
        chk("R10 exception makes no request", {31'd0, tbl_req}, 32'd0);
    endtask

    task automatic t_priority();
        wr(A_TVEC, 32'h0000_0200);
        wr(A_IE, 32'h0000_0888);
        wr(A_STATUS, 32'h0000_0008);
        @(negedge clk);
        exc_valid  = 1'b1;
        exc_cause  = 5'd4;
        exc_pc     = 32'h0000_0800;
        exc_info   = 32'h0000_0ABC;
        irq_sw     = 1'b1;
        mret_valid = 1'b1;
        @(negedge clk);
        exc_valid  = 1'b0;
        mret_valid = 1'b0;
        irq_sw     = 1'b0;
        chk("R12 trap_taken", {31'd0, trap_taken}, 32'd1);
        chk("R12 exception redirect", redirect_pc, 32'h0000_0200);
        rd_chk("R12 exception cause", A_CAUSE, 32'h0000_0004);
        rd_chk("R12 exception epc", A_EPC, 32'h0000_0800);
        rd_chk("R12 return not applied", A_STATUS, 32'h0000_1880);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        csr_we     = 1'b0;
        csr_addr   = '0;
        csr_wdata  = '0;
        irq_sw     = 1'b0;
        irq_timer  = 1'b0;
        irq_ext    = 1'b0;
        exc_valid  = 1'b0;
        exc_cause  = '0;
        exc_pc     = '0;
        exc_info   = '0;
        next_pc    = '0;
        mret_valid = 1'b0;
        tbl_rvalid = 1'b0;
        tbl_rdata  = '0;
        tbl_err    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_csr_masks();
        t_exceptions();
        t_return();
        t_interrupts();
        t_table();
        t_priority();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule